// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block turns the CPU's 32 KB program window at 0x8000-0xFFFF into physical program ROM page numbers. The window is split into four 8 KB slots. Each slot is given an 8 KB page through one of several banking schemes:

- a classic scheme in which two slots can be switched and two are fixed near the top of the ROM, with the page split into an inner part and an outer part according to the mode;
- a mirrored 16 KB mapping;
- a linear 32 KB mapping;
- an extended scheme in which all four slots can be switched.

Software programs the block through CPU writes. Writes in 0x5000-0x5FFF set the outer base, the mode and the extended flag. Writes in 0x8000-0x9FFF select a bank register and load it. The memory system presents the slot being read and receives that slot's page. All four pages are also output side by side.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, bank registers 0..7 hold 0,2,4,5,6,7,0,1, the extended registers 0..3 hold 0xFE,0xFF,0xFF,0xFF, and mode, outer base, swap flag and extended flag are zero. Slots 0..3 therefore map to pages 0, 1, 0x3E and 0x3F.
- R2: In modes 0, 1 and 2 with the extended flag clear, the inner mask is 0x3F shifted right by the mode number. The outer part is the base shifted left by one, with the inner-mask bits cleared. A slot's page is (source AND inner) OR outer. The sources for slots 0..3 are bank register 6, bank register 7, 0xFE and 0xFF.
- R3: When the swap flag is set in modes 0 to 2, slots 0 and 2 exchange their sources. Slots 1 and 3 are not affected.
- R4: In modes 0 to 2 with the extended flag set, extended registers 0 and 1 replace the constants 0xFE and 0xFF. No inner mask is applied, and each page is source OR (base shifted left by one).
- R5: In mode 3, slots 0 and 2 get (base shifted left by one), and slots 1 and 3 get that value OR 1.
- R6: In mode 4, slot s (s = 0..3) gets ((base AND 0x3FE) shifted left by one) OR s.
- R7: In modes 5, 6 and 7, all four slot pages keep the values they had when the mode was left. They do not change while base or bank registers are rewritten.
- R8: A write decodes as an outer-register write when the address is in 0x4000-0x5FFF and (address AND 0x5010) = 0x5010. Address bits 1:0 pick the register:
  - register 0: data bits 2:0 set the mode, data bit 7 sets base bit 8, and data bit 3 sets base bit 7;
  - register 1: data bits 6:0 set base bits 6:0;
  - register 2: data bit 6 sets base bit 9;
  - register 3: data bit 1 sets the extended flag.
- R9: A write with (address AND 0xE001) = 0x8000 stores data bits 3:0 as the select index and data bit 6 as the swap flag. A write with (address AND 0xE001) = 0x8001 loads the register named by the index; only its low three bits count unless the extended flag is set. Indexes 0-7 are bank registers, 8-11 are extended registers 0-3, and 12-15 are dropped. Every other write leaves all pages unchanged.
- R10: The mapping is combinational from register state. A page read in the cycle after a register write reflects that write.
- R11: Every page is reduced modulo ROM_PAGES, which is a power of two of at least 4.
- R12: `rd_page` equals the page of slot `rd_slot`. `slot_pages` holds slot s in bits [s*PAGE_W +: PAGE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_slot | input | 2 | Slot currently being read |
| rd_page | output | PAGE_W | Physical page of `rd_slot` |
| slot_pages | output | 4*PAGE_W | Physical pages of all four slots |

## Verification
A single register-0 write can switch into a hold mode (5-7) and also change the base in the same cycle. The frozen mapping must then be the one computed from the old base, not the new one. Random traffic produces this case often, and directed writes force it: one enters mode 5 with a new base, and later ones rewrite the base and a bank register while the hold mode is active. The bench judges the outputs against a model whose held copy is taken from the state before each write. Selecting an index and loading a register in consecutive cycles is also checked, so that the load uses the freshly written index.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

   localparam int BASE_W     = 10;
   localparam int REG_W      = 8;
   localparam int MODE_W     = 3;
   localparam int SEL_W      = 4;
   localparam int SLOTS      = 4;
   localparam int N_BANK     = 8;
   localparam int N_EXT      = 4;
   localparam int RAW_W      = BASE_W + 1;
   localparam int FIRST_HOLD = 5;

   typedef logic [RAW_W-1:0] raw_page_t;

   typedef struct packed {
      logic [N_BANK-1:0][REG_W-1:0] bank;
      logic [N_EXT-1:0][REG_W-1:0]  ext;
      logic [MODE_W-1:0]            mode;
      logic [BASE_W-1:0]            base;
      logic [SEL_W-1:0]             sel;
      logic                         swap;
      logic                         ext_mode;
   } map_state_t;

   function automatic logic [REG_W-1:0] bank_init(input int idx);
      if (idx == 0)      return '0;
      else if (idx == 1) return REG_W'(2);
      else if (idx < 6)  return REG_W'(idx + 2);
      else               return REG_W'(idx - 6);
   endfunction

   function automatic map_state_t state_init();
      map_state_t s;
      s = '0;
      for (int i = 0; i < N_BANK; i++) s.bank[i] = bank_init(i);
      for (int i = 0; i < N_EXT; i++)  s.ext[i]  = (i == 0) ? 8'hFE : 8'hFF;
      return s;
   endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
   import prg_map_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [15:0]      wr_addr,
   input  logic [REG_W-1:0] wr_data,
   output map_state_t       st
);

   logic             outer_hit;
   logic             sel_hit;
   logic             load_hit;
   logic [SEL_W-1:0] idx;

   // outer registers: 0x4000-0x5FFF with address bits 14, 12 and 4 all set
   assign outer_hit = (wr_addr[15:13] == 3'b010) && wr_addr[12] && wr_addr[4];
   assign sel_hit   = wr_addr[15] && (wr_addr[14:13] == 2'b00) && !wr_addr[0];
   assign load_hit  = wr_addr[15] && (wr_addr[14:13] == 2'b00) &&  wr_addr[0];
   assign idx       = st.ext_mode ? st.sel : {1'b0, st.sel[2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= state_init();
      end else if (wr_en) begin
         if (outer_hit) begin
            unique case (wr_addr[1:0])
               2'd0: begin
                  st.mode    <= wr_data[2:0];
                  st.base[8] <= wr_data[7];
                  st.base[7] <= wr_data[3];
               end
               2'd1: st.base[6:0] <= wr_data[6:0];
               2'd2: st.base[9]   <= wr_data[6];
               default: st.ext_mode <= wr_data[1];
            endcase
         end else if (sel_hit) begin
            st.sel  <= wr_data[SEL_W-1:0];
            st.swap <= wr_data[6];
         end else if (load_hit) begin
            if (idx < SEL_W'(N_BANK))
               st.bank[idx[2:0]] <= wr_data;
            else if (idx < SEL_W'(N_BANK + N_EXT))
               st.ext[idx[1:0]] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/prg_slot_calc.sv
module prg_slot_calc
   import prg_map_pkg::*;
(
   input  map_state_t              st,
   output raw_page_t [SLOTS-1:0]   raw
);

   raw_page_t        base2;
   raw_page_t        inner;
   raw_page_t        outer;
   raw_page_t        quad;
   logic [REG_W-1:0] fixed_lo;
   logic [REG_W-1:0] fixed_hi;
   logic [SLOTS-1:0][REG_W-1:0] src;

   assign base2    = {st.base, 1'b0};
   assign inner    = RAW_W'(11'h03F >> st.mode);
   assign outer    = base2 & ~inner;
   assign quad     = {st.base[BASE_W-1:1], 2'b00};
   assign fixed_lo = st.ext_mode ? st.ext[0] : 8'hFE;
   assign fixed_hi = st.ext_mode ? st.ext[1] : 8'hFF;

   assign src[0] = st.swap ? fixed_lo   : st.bank[6];
   assign src[1] = st.bank[7];
   assign src[2] = st.swap ? st.bank[6] : fixed_lo;
   assign src[3] = fixed_hi;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      raw_page_t wide;
      assign wide = RAW_W'(src[s]);
      always_comb begin
         unique case (st.mode)
            3'd0, 3'd1, 3'd2:
               raw[s] = st.ext_mode ? (wide | base2) : ((wide & inner) | outer);
            3'd3:    raw[s] = base2 | RAW_W'(s % 2);
            3'd4:    raw[s] = quad | RAW_W'(s);
            default: raw[s] = '0;
         endcase
      end
   end

endmodule

// File: rtl/prg_map_hold.sv
module prg_map_hold
   import prg_map_pkg::*;
#(
   parameter int PAGE_W = 8
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [MODE_W-1:0]            mode,
   input  raw_page_t [SLOTS-1:0]        raw,
   input  logic [1:0]                   rd_slot,
   output logic [SLOTS-1:0][PAGE_W-1:0] pages,
   output logic [PAGE_W-1:0]            rd_page
);

   logic [SLOTS-1:0][PAGE_W-1:0] live;
   logic [SLOTS-1:0][PAGE_W-1:0] held;
   logic                         hold_mode;

   assign hold_mode = mode >= MODE_W'(FIRST_HOLD);

   for (genvar s = 0; s < SLOTS; s++) begin : g_wrap
      if (PAGE_W <= RAW_W) begin : g_cut
         assign live[s] = raw[s][PAGE_W-1:0];
      end else begin : g_ext
         assign live[s] = {{(PAGE_W-RAW_W){1'b0}}, raw[s]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held <= '0;
      else if (!hold_mode) held <= live;
   end

   assign pages   = hold_mode ? held : live;
   assign rd_page = pages[rd_slot];

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import prg_map_pkg::*;
#(
   parameter int ROM_PAGES = 256,
   localparam int PAGE_W   = $clog2(ROM_PAGES)
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [15:0]               wr_addr,
   input  logic [7:0]                wr_data,
   input  logic [1:0]                rd_slot,
   output logic [PAGE_W-1:0]         rd_page,
   output logic [SLOTS*PAGE_W-1:0]   slot_pages
);

   if (ROM_PAGES < 4 || (ROM_PAGES & (ROM_PAGES - 1)) != 0) begin : g_bad_size
      $error("prg_bank_mapper: ROM_PAGES must be a power of two of at least 4");
   end

   map_state_t                    st;
   raw_page_t [SLOTS-1:0]         raw;
   logic [SLOTS-1:0][PAGE_W-1:0]  pages;
   logic [MODE_W-1:0]             cur_mode;

   assign cur_mode = st.mode;

   prg_map_regs i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .st      (st)
   );

   prg_slot_calc i_calc (
      .st  (st),
      .raw (raw)
   );

   prg_map_hold #(.PAGE_W(PAGE_W)) i_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (cur_mode),
      .raw     (raw),
      .rd_slot (rd_slot),
      .pages   (pages),
      .rd_page (rd_page)
   );

   assign slot_pages = pages;

endmodule

// File: rtl/prg_map_checker.sv
module prg_map_checker #(
   parameter int PAGE_W = 8
)(
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [15:0]         wr_addr,
   input logic [1:0]          rd_slot,
   input logic [PAGE_W-1:0]   rd_page,
   input logic [4*PAGE_W-1:0] slot_pages,
   input logic [2:0]          mode
);

   logic [PAGE_W-1:0] p0, p1, p2, p3;
   logic              in_hold;
   logic              dead_write;

   assign p0 = slot_pages[0*PAGE_W +: PAGE_W];
   assign p1 = slot_pages[1*PAGE_W +: PAGE_W];
   assign p2 = slot_pages[2*PAGE_W +: PAGE_W];
   assign p3 = slot_pages[3*PAGE_W +: PAGE_W];
   assign in_hold = mode >= 3'd5;
   assign dead_write = wr_en && ((wr_addr[15] && wr_addr[14:13] != 2'b00) ||
                                 (wr_addr[15:14] == 2'b00));

   AST_READ_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_page == slot_pages[rd_slot*PAGE_W +: PAGE_W]);                   // R12

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold && $past(in_hold)) |-> $stable(slot_pages));              // R7

   AST_MIRROR_16K: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3) |-> (p0 == p2 && p1 == p3 && p1 == (p0 | PAGE_W'(1))));  // R5

   AST_LINEAR_32K: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4) |-> (p0[1:0] == 2'd0 && p1 == (p0 | PAGE_W'(1)) &&
                          p2 == (p0 | PAGE_W'(2)) && p3 == (p0 | PAGE_W'(3))));  // R6

   AST_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dead_write |=> $stable(slot_pages));                                // R9

endmodule

bind prg_bank_mapper prg_map_checker #(.PAGE_W(PAGE_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .rd_slot    (rd_slot),
   .rd_page    (rd_page),
   .slot_pages (slot_pages),
   .mode       (cur_mode)
);

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;

   localparam int CLK_PERIOD = 10;
   localparam int ROM_PAGES  = 512;
   localparam int PW         = $clog2(ROM_PAGES);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [15:0]     wr_addr = '0;
   logic [7:0]      wr_data = '0;
   logic [1:0]      rd_slot = '0;
   logic [PW-1:0]   rd_page;
   logic [4*PW-1:0] slot_pages;

   int n_run  = 0;
   int n_fail = 0;

   // reference model state
   int mb[8];
   int me[4];
   int msel, mswap, mmode, mbase, mext;
   int held[4];

   always #(CLK_PERIOD/2) clk = ~clk;

   prg_bank_mapper #(.ROM_PAGES(ROM_PAGES)) i_prg_bank_mapper (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_slot(rd_slot), .rd_page(rd_page),
      .slot_pages(slot_pages)
   );

   function automatic int live_page(int s);
      int b2, src, inner, v, lo, hi;
      b2 = mbase * 2;
      lo = mext ? me[0] : 'hFE;
      hi = mext ? me[1] : 'hFF;
      case (s)
         0: src = mswap ? lo : mb[6];
         1: src = mb[7];
         2: src = mswap ? mb[6] : lo;
         default: src = hi;
      endcase
      if (mmode <= 2) begin
         inner = 'h3F >> mmode;
         v = mext ? (src | b2) : ((src & inner) | (b2 & ~inner));
      end else if (mmode == 3) v = b2 | (s % 2);
      else v = ((mbase & 'h3FE) * 2) | s;
      return v % ROM_PAGES;
   endfunction

   function automatic int exp_page(int s);
      return (mmode >= 5) ? held[s] : live_page(s);
   endfunction

   function automatic string mode_tag();
      if (mmode >= 5) return "R7";
      if (mmode == 3) return "R5";
      if (mmode == 4) return "R6";
      if (mswap != 0) return "R3";
      return mext ? "R4" : "R2";
   endfunction

   task automatic model_reset();
      mb = '{0, 2, 4, 5, 6, 7, 0, 1};
      me = '{'hFE, 'hFF, 'hFF, 'hFF};
      msel = 0; mswap = 0; mmode = 0; mbase = 0; mext = 0;
      for (int s = 0; s < 4; s++) held[s] = 0;
   endtask

   task automatic model_write(int a, int d);
      int idx;
      if (mmode < 5) for (int s = 0; s < 4; s++) held[s] = live_page(s);
      if (a >= 'h4000 && a < 'h6000 && (a & 'h5010) == 'h5010) begin
         case (a % 4)
            0: begin
               mmode = d & 7;
               mbase = (mbase & ~'h180) | (((d >> 7) & 1) << 8) | (((d >> 3) & 1) << 7);
            end
            1: mbase = (mbase & ~'h7F) | (d & 'h7F);
            2: mbase = (mbase & ~'h200) | (((d >> 6) & 1) << 9);
            default: mext = (d >> 1) & 1;
         endcase
      end else if ((a & 'hE001) == 'h8000) begin
         msel = d & 'hF; mswap = (d >> 6) & 1;
      end else if ((a & 'hE001) == 'h8001) begin
         idx = mext ? msel : (msel & 7);
         if (idx < 8) mb[idx] = d;
         else if (idx < 12) me[idx - 8] = d;
      end
   endtask

   task automatic check(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // called away from the clock edge, well inside the low phase
   task automatic check_all(string tag);
      for (int s = 0; s < 4; s++) begin
         rd_slot = 2'(s);
         #1;
         check(tag, $sformatf("slot %0d page", s), int'(rd_page), exp_page(s));
         check("R12", $sformatf("flat slot %0d", s),
               int'(slot_pages[s*PW +: PW]), exp_page(s));
      end
   endtask

   task automatic do_write(int a, int d, string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
      check_all(tag);
   endtask

   function automatic int rand_addr();
      int r, k;
      r = int'($urandom);
      k = int'($urandom_range(0, 9));
      case (k)
         0, 1, 2: return 'h5010 | (r & 'h0FEF);
         3, 4:    return 'h8000 | (r & 'h1FFE);
         5, 6, 7: return 'h8001 | (r & 'h1FFE);
         8:       return 'hA000 | (r & 'h5FFF);
         default: return 'h4000 | (r & 'h1FEF);
      endcase
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R10: select then load in back-to-back cycles
      do_write('h8000, 'h06, "R10");
      do_write('h8001, 'h15, "R10");
      // R3: swap exchanges slots 0 and 2
      do_write('h8000, 'h46, "R3");
      // R8: base bits from three registers, mode 1
      do_write('h5011, 'h55, "R8");
      do_write('h5012, 'h40, "R8");
      do_write('h5010, 'h89, "R8");
      // R11: base at maximum wraps modulo ROM_PAGES
      do_write('h5011, 'h7F, "R11");
      // R5 / R6
      do_write('h5010, 'h03, "R5");
      do_write('h5010, 'h04, "R6");
      // R4: extended mode, index 9 loads extended register 1
      do_write('h5013, 'h02, "R4");
      do_write('h5010, 'h00, "R4");
      do_write('h8000, 'h09, "R4");
      do_write('h8001, 'h33, "R4");
      // R9: index 12 dropped, non-decoded writes ignored
      do_write('h8000, 'h0C, "R9");
      do_write('h8001, 'hAA, "R9");
      do_write('hC001, 'h77, "R9");
      do_write('h4011, 'h01, "R9");
      // R7: enter hold with a new base in the same write, then rewrite
      do_write('h5010, 'h8D, "R7");
      do_write('h5011, 'h12, "R7");
      do_write('h8000, 'h07, "R7");
      do_write('h8001, 'h3C, "R7");
      do_write('h5010, 'h00, "R10");

      for (int i = 0; i < 3000; i++) begin
         int a, d;
         a = rand_addr();
         d = int'($urandom_range(0, 255));
         do_write(a, d, mode_tag());
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule